// File: doc/BRIEF.md
# Branch Resolution Unit

This unit settles, for each control-transfer instruction, whether the transfer happens and which address is fetched next. It handles three ways of expressing a condition in one place. The first tests a stored condition flag. The second compares two register operands inside the branch itself. The third tests a general register that an earlier set-less-than or compare operation wrote. The same unit also forms jump targets. A PC-relative target is the PC plus the offset. An absolute target joins the upper PC bits to the offset field. A register target is taken straight from an operand. For calls it raises a link request that carries the return address.

The four condition flags live in a small register file inside the unit. They are loaded from the ALU result, carry-out and overflow whenever the flag-write enable is high at a rising clock edge. Every branch decision is combinational from the current inputs and the flags stored at that moment. All pins are plain control and data signals with no handshake: an instruction is presented for exactly the cycle in which it is resolved.

Top module: `branch_resolver`

## Requirements
- R1: While reset is active, and after it is released, all four flags read as 0. Therefore no flag branch is taken until a flag write sets a flag.
- R2: On a rising edge with `flag_we` high, the flags are loaded as follows: Z is set when `alu_result` is all zeros, N is `alu_result[W-1]`, V is `alu_ovf` (signed two's-complement overflow) and C is `alu_carry` (unsigned carry-out).
- R3: On any rising edge with `flag_we` low, all four flags keep their value.
- R4: Kind codes 1, 2, 3 and 4 are taken when Z, N, V or C is 1, respectively. The flags tested are those stored before any write in the same cycle.
- R5: Kind 5 is taken when `op_a == op_b`. Kind 6 is taken when they differ.
- R6: Kind 7 is taken when `op_a` is nonzero. Kind 8 is taken when `op_a` is zero.
- R7: When a conditional kind (1 to 8) is taken, `next_pc` is `pc + offset`. When it is not taken, `next_pc` is `pc + 4`.
- R8: Kinds 9 (jump) and 10 (jump and link) are always taken. Their `next_pc` is `{pc[W-1:JB+2], offset[JB-1:0], 2'b00}`, where JB = 26.
- R9: Kinds 11 (register jump) and 12 (register jump and link) are always taken, with `next_pc = op_a`.
- R10: `link_we` is 1 exactly for kinds 10 and 12, and `link_addr` is then `pc + 4`. For every other kind, `link_we` is 0.
- R11: Kind 0 (no branch) and the unused codes 13 to 15 are not taken, give `next_pc = pc + 4` and give no link request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the flag register |
| alu_result | input | W | ALU result offered for flag update |
| alu_carry | input | 1 | Unsigned carry-out of the adder |
| alu_ovf | input | 1 | Signed overflow of the adder |
| flag_we | input | 1 | Load flags at the next rising edge |
| br_kind | input | 4 | Transfer kind code (see R4 to R11) |
| op_a | input | W | First register operand / register target |
| op_b | input | W | Second register operand |
| pc | input | W | Address of the transfer instruction |
| offset | input | W | Sign-extended byte offset or jump field |
| taken | output | 1 | Transfer is taken |
| next_pc | output | W | Address to fetch next |
| link_we | output | 1 | Write return address to the link register |
| link_addr | output | W | Return address (pc + 4) |

## Verification
A flag write and a flag-tested branch can occur in the same cycle. This happens when the ALU operation that updates the flags is directly followed by a branch on those flags in a pipeline. The bench provokes this case with two steps. First, it holds Z at 0 and presents kind 1 together with `flag_we` high and a zero `alu_result`. Before the edge it expects not taken, because the old flag is in force. After the edge it expects taken, because the new flag now applies. A link request is likewise judged together with the target it travels with, in the same cycle.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [3:0] {
    BK_SEQ  = 4'd0,
    BK_FZ   = 4'd1,
    BK_FN   = 4'd2,
    BK_FV   = 4'd3,
    BK_FC   = 4'd4,
    BK_EQ   = 4'd5,
    BK_NE   = 4'd6,
    BK_RNZ  = 4'd7,
    BK_RZ   = 4'd8,
    BK_J    = 4'd9,
    BK_JAL  = 4'd10,
    BK_JR   = 4'd11,
    BK_JALR = 4'd12
  } brk_e;

  typedef enum logic [1:0] {
    TS_SEQ = 2'd0,
    TS_REL = 2'd1,
    TS_ABS = 2'd2,
    TS_REG = 2'd3
  } tsel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/brx_flag_store.sv
module brx_flag_store
  import brx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] res,
  input  logic         carry,
  input  logic         ovf,
  output flags_t       flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (we) begin
      flags.z <= (res == '0);
      flags.n <= res[W-1];
      flags.v <= ovf;
      flags.c <= carry;
    end
  end

  // R3: a cycle without write leaves every flag untouched
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flags));

  // R2: zero and sign flags follow the written result
  a_r2_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (flags.z == ($past(res) == '0)) && (flags.n == $past(res[W-1])));

  // R2: carry and overflow are captured from the adder
  a_r2_carry_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (flags.c == $past(carry)) && (flags.v == $past(ovf)));
endmodule

// File: rtl/brx_cond_eval.sv
module brx_cond_eval
  import brx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   kind,
  input  flags_t       flags,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         taken,
  output tsel_e        tsel,
  output logic         link
);
  logic eq_ab;
  logic a_zero;

  assign eq_ab  = (op_a == op_b);
  assign a_zero = (op_a == '0);

  always_comb begin
    taken = 1'b0;
    tsel  = TS_SEQ;
    link  = 1'b0;
    case (kind)
      BK_FZ:   begin taken = flags.z;  tsel = TS_REL; end
      BK_FN:   begin taken = flags.n;  tsel = TS_REL; end
      BK_FV:   begin taken = flags.v;  tsel = TS_REL; end
      BK_FC:   begin taken = flags.c;  tsel = TS_REL; end
      BK_EQ:   begin taken = eq_ab;    tsel = TS_REL; end
      BK_NE:   begin taken = !eq_ab;   tsel = TS_REL; end
      BK_RNZ:  begin taken = !a_zero;  tsel = TS_REL; end
      BK_RZ:   begin taken = a_zero;   tsel = TS_REL; end
      BK_J:    begin taken = 1'b1;     tsel = TS_ABS; end
      BK_JAL:  begin taken = 1'b1;     tsel = TS_ABS; link = 1'b1; end
      BK_JR:   begin taken = 1'b1;     tsel = TS_REG; end
      BK_JALR: begin taken = 1'b1;     tsel = TS_REG; link = 1'b1; end
      default: begin taken = 1'b0;     tsel = TS_SEQ; end
    endcase
  end

  // R10: a link request only ever comes with a taken transfer
  always_comb begin
    if (link) a_r10_link_taken: assert (taken);
  end
endmodule

// File: rtl/brx_target_gen.sv
module brx_target_gen
  import brx_pkg::*;
#(
  parameter int W  = 32,
  parameter int JB = 26
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] offset,
  input  logic [W-1:0] op_a,
  input  tsel_e        tsel,
  input  logic         taken,
  output logic [W-1:0] next_pc,
  output logic [W-1:0] pc_seq
);
  localparam int HI = W - JB - 2;

  logic [W-1:0] rel_tgt;
  logic [W-1:0] abs_tgt;

  assign pc_seq  = pc + W'(4);
  assign rel_tgt = pc + offset;

  generate
    if (HI > 0) begin : g_hi
      assign abs_tgt = {pc[W-1:JB+2], offset[JB-1:0], 2'b00};
    end else begin : g_nohi
      assign abs_tgt = {offset[W-3:0], 2'b00};
    end
  endgenerate

  always_comb begin
    next_pc = pc_seq;
    if (taken) begin
      case (tsel)
        TS_REL:  next_pc = rel_tgt;
        TS_ABS:  next_pc = abs_tgt;
        TS_REG:  next_pc = op_a;
        default: next_pc = pc_seq;
      endcase
    end
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brx_pkg::*;
#(
  parameter int W  = 32,
  parameter int JB = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] alu_result,
  input  logic         alu_carry,
  input  logic         alu_ovf,
  input  logic         flag_we,
  input  logic [3:0]   br_kind,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] offset,
  output logic         taken,
  output logic [W-1:0] next_pc,
  output logic         link_we,
  output logic [W-1:0] link_addr
);
  flags_t       flags;
  tsel_e        tsel;
  logic [W-1:0] pc_seq;

  brx_flag_store #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .res(alu_result),
    .carry(alu_carry), .ovf(alu_ovf), .flags(flags)
  );

  brx_cond_eval #(.W(W)) u_cond (
    .kind(br_kind), .flags(flags), .op_a(op_a), .op_b(op_b),
    .taken(taken), .tsel(tsel), .link(link_we)
  );

  brx_target_gen #(.W(W), .JB(JB)) u_tgt (
    .pc(pc), .offset(offset), .op_a(op_a), .tsel(tsel),
    .taken(taken), .next_pc(next_pc), .pc_seq(pc_seq)
  );

  assign link_addr = pc_seq;

  // R7: an untaken transfer falls through to the next word
  a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> next_pc == pc + W'(4));

  // R11: unused kind codes never transfer or link
  a_r11_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind > 4'd12) |-> (!taken && !link_we));

  // R9: register jumps land on the operand
  a_r9_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 4'd11 || br_kind == 4'd12) |-> (taken && next_pc == op_a));
endmodule

// File: tb/branch_resolver_test.sv
module branch_resolver_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] alu_result = '0;
  logic         alu_carry = 1'b0;
  logic         alu_ovf = 1'b0;
  logic         flag_we = 1'b0;
  logic [3:0]   br_kind = 4'd0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] pc = '0;
  logic [W-1:0] offset = '0;
  logic         taken;
  logic [W-1:0] next_pc;
  logic         link_we;
  logic [W-1:0] link_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  branch_resolver #(.W(W), .JB(26)) uut (
    .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .flag_we(flag_we), .br_kind(br_kind), .op_a(op_a),
    .op_b(op_b), .pc(pc), .offset(offset), .taken(taken), .next_pc(next_pc),
    .link_we(link_we), .link_addr(link_addr)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input logic [3:0] k, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] p, input logic [W-1:0] o);
    @(negedge clk);
    br_kind = k; op_a = a; op_b = b; pc = p; offset = o;
    #1;
  endtask

  task automatic write_flags(input logic [W-1:0] r, input logic c, input logic v);
    @(negedge clk);
    alu_result = r; alu_carry = c; alu_ovf = v; flag_we = 1'b1;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  // flags observed through kinds 1..4: returns {Z,N,V,C}
  task automatic read_flags(output logic [3:0] f);
    for (int i = 1; i <= 4; i++) begin
      present(4'(i), '0, '0, 32'h100, 32'h40);
      f[4-i] = taken;
    end
  endtask

  task automatic t_reset();
    logic [3:0] f;
    read_flags(f);
    chk("R1 flags after reset", {28'd0, f}, 32'h0);
    present(4'd1, '0, '0, 32'h100, 32'h40);
    chk("R1 next_pc after reset", next_pc, 32'h104);
  endtask

  task automatic t_capture();
    logic [3:0] f;
    write_flags(32'h0, 1'b1, 1'b0);
    read_flags(f);
    chk("R2 capture zero/carry", {28'd0, f}, 32'h9);
    write_flags(32'h8000_0000, 1'b0, 1'b1);
    read_flags(f);
    chk("R2 capture sign/overflow", {28'd0, f}, 32'h6);
  endtask

  task automatic t_hold();
    logic [3:0] f;
    @(negedge clk);
    alu_result = 32'h0; alu_carry = 1'b1; alu_ovf = 1'b0; flag_we = 1'b0;
    repeat (3) @(negedge clk);
    read_flags(f);
    chk("R3 flags hold", {28'd0, f}, 32'h6);
  endtask

  task automatic t_same_cycle();
    // Z currently 0; write a zero result while branching on Z
    @(negedge clk);
    br_kind = 4'd1; pc = 32'h2000; offset = 32'h20;
    alu_result = 32'h0; alu_carry = 1'b0; alu_ovf = 1'b0; flag_we = 1'b1;
    #1;
    chk("R4 old flag used in write cycle", {31'd0, taken}, 32'h0);
    chk("R7 fallthrough in write cycle", next_pc, 32'h2004);
    @(negedge clk);
    flag_we = 1'b0;
    #1;
    chk("R4 new flag after write", {31'd0, taken}, 32'h1);
    chk("R7 relative target", next_pc, 32'h2020);
  endtask

  task automatic t_compare();
    present(4'd5, 32'h55, 32'h55, 32'h1000, 32'hFFFF_FFF0);
    chk("R5 eq equal taken", {31'd0, taken}, 32'h1);
    chk("R7 backward target", next_pc, 32'h0FF0);
    present(4'd5, 32'h55, 32'h56, 32'h1000, 32'hFFFF_FFF0);
    chk("R5 eq differ not taken", next_pc, 32'h1004);
    present(4'd6, 32'h55, 32'h56, 32'h1000, 32'h10);
    chk("R5 ne differ taken", next_pc, 32'h1010);
    present(4'd6, 32'h7, 32'h7, 32'h1000, 32'h10);
    chk("R5 ne equal not taken", {31'd0, taken}, 32'h0);
  endtask

  task automatic t_regtest();
    present(4'd7, 32'h1, '0, 32'h3000, 32'h8);
    chk("R6 rnz nonzero taken", next_pc, 32'h3008);
    present(4'd7, 32'h0, '0, 32'h3000, 32'h8);
    chk("R6 rnz zero not taken", next_pc, 32'h3004);
    present(4'd8, 32'h0, '0, 32'h3000, 32'h8);
    chk("R6 rz zero taken", next_pc, 32'h3008);
    present(4'd8, 32'h8000_0000, '0, 32'h3000, 32'h8);
    chk("R6 rz nonzero not taken", {31'd0, taken}, 32'h0);
  endtask

  task automatic t_jumps();
    present(4'd9, '0, '0, 32'hA000_0010, 32'h0123_4567);
    chk("R8 jump target", next_pc, 32'hA48D_159C);
    chk("R10 no link on plain jump", {31'd0, link_we}, 32'h0);
    present(4'd10, '0, '0, 32'hA000_0010, 32'hFFFF_FFFF);
    chk("R8 jal target", next_pc, 32'hAFFF_FFFC);
    chk("R10 jal link", {31'd0, link_we}, 32'h1);
    chk("R10 jal link addr", link_addr, 32'hA000_0014);
    present(4'd11, 32'h0000_4444, '0, 32'h500, '0);
    chk("R9 jr target", next_pc, 32'h0000_4444);
    chk("R10 no link on jr", {31'd0, link_we}, 32'h0);
    present(4'd12, 32'h0000_8888, '0, 32'h500, '0);
    chk("R9 jalr target", next_pc, 32'h0000_8888);
    chk("R10 jalr link addr", {link_we, link_addr[30:0]}, 32'h8000_0504);
    present(4'd5, 32'h1, 32'h1, 32'h500, 32'h4);
    chk("R10 no link on branch", {31'd0, link_we}, 32'h0);
  endtask

  task automatic t_unused();
    for (int k = 13; k <= 15; k++) begin
      present(4'(k), 32'h1234, 32'h1234, 32'h600, 32'h80);
      chk("R11 unused code", {taken, link_we, next_pc[29:0]}, 32'h604);
    end
    present(4'd0, 32'h1234, 32'h1234, 32'h600, 32'h80);
    chk("R11 no-branch code", {taken, link_we, next_pc[29:0]}, 32'h604);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_hold();
    t_same_cycle();
    t_compare();
    t_regtest();
    t_jumps();
    t_unused();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule